// File: doc/BRIEF.md
# Per-tile chain claim controller

This controller sits in every processing tile of a two-dimensional mesh. Its job is to help an application take a linear chain of neighbouring tiles. A claim request arrives on one of the four neighbour ports, or on the local seed port of a border tile. The request carries the number of tiles that are still needed. A free tile takes itself, subtracts one from the count and passes the request on to one free neighbour. Each hop takes one clock cycle. When the count runs out, or no neighbour can take the request, the last tile starts a confirm wave. That wave runs back along the chain, and each tile adds one to the count it carries. The initiator therefore learns how many tiles it actually got.

Each tile records the port that claimed it and the port it forwarded to. A later release request follows the same path forward. A release-acknowledge wave then returns from the last tile to the initiator, and each tile marks itself free as the wave passes. The tile exposes a busy level to its neighbours. A tile that is already claimed answers any new request with a one-cycle reject and keeps its state.

Top module: `tile_claim_ctrl`

## Requirements
- R1: After reset the tile is free: busy_out is low and every pulse output is low.
- R2: A free tile that accepts a request with count C ≥ 2 forwards it in the next cycle on exactly one port with count C−1. The port is the first free one in index order 0 (east), 1 (south), 2 (west), 3 (north). Among simultaneous requests, the ports 0..3 win in that order and the local seed has the lowest priority.
- R3: A request is never forwarded to the port it came from, nor to a port whose busy_in bit is high. A request with count ≤ 1 is confirmed to its source in the next cycle with count 1.
- R4: If a request with count ≥ 2 has no port left to try, the tile confirms to its source in the next cycle with the partial count 1.
- R5: A confirm with count K from the forwarded-to port is passed to the source port in the next cycle with count K+1.
- R6: A reject from the forwarded-to port makes the tile try the next eligible port two cycles later. Ports already tried are skipped. If no port is left, the tile gives the partial confirm of R4 instead.
- R7: A request that reaches a claimed tile, or that loses a simultaneous arrival, gets a one-cycle reject on its own port in the next cycle. The tile's state stays as it was.
- R8: A release from the source port is passed to the forwarded-to port in the next cycle. A tile with no forwarded-to port instead acknowledges to its source in the next cycle and goes free. A release on any other port has no effect.
- R9: A release acknowledge from the forwarded-to port is passed to the source port in the next cycle, and the tile goes free in that same cycle.
- R10: The seed port works only when SEED_EN is 1. When SEED_EN is 0, a seed request gives no reply and the tile stays free.
- R11: busy_out is high from the cycle after a request is accepted until the cycle in which the tile sends its own release acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_in | input | 4 | Busy level of each neighbour |
| inv_in | input | 4 | Claim request pulse per port |
| inv_cnt_in | input | 4×CW | Tiles still needed, per port |
| cfm_in | input | 4 | Confirm pulse per port |
| cfm_cnt_in | input | 4×CW | Claimed count carried by a confirm |
| rej_in | input | 4 | Reject pulse per port |
| rel_in | input | 4 | Release pulse per port |
| rak_in | input | 4 | Release acknowledge pulse per port |
| seed_inv | input | 1 | Local claim request (border tiles) |
| seed_cnt | input | CW | Count of the local claim request |
| seed_rel | input | 1 | Local release request |
| busy_out | output | 1 | This tile is claimed or in transit |
| inv_out | output | 4 | Forwarded claim pulse per port |
| inv_cnt_out | output | CW | Count sent with inv_out |
| cfm_out | output | 4 | Confirm pulse per port |
| cfm_cnt_out | output | CW | Count sent with cfm_out or seed_cfm |
| rej_out | output | 4 | Reject pulse per port |
| rel_out | output | 4 | Forwarded release pulse per port |
| rak_out | output | 4 | Release acknowledge pulse per port |
| seed_cfm | output | 1 | Confirm to the local initiator |
| seed_rej | output | 1 | Reject to the local initiator |
| seed_rak | output | 1 | Release acknowledge to the local initiator |

## Verification
Every output is a register. A forward, confirm, reject, release or acknowledge caused by an input sampled at one edge therefore shows on the ports right after that same edge. The one exception is a retry after a reject: it passes through a retry state and appears one edge later. The bench drives each stimulus for exactly one cycle just after an edge, then samples just after the next edge (two edges for a retry). It then checks that pulses have dropped again a cycle later. The sweep covers every entry port, every neighbour busy pattern and two request counts.

// File: rtl/tile_claim_pkg.sv
package tile_claim_pkg;
  typedef enum logic [2:0] {
    ST_FREE,
    ST_FORWARDING,
    ST_WAIT_CONFIRM,
    ST_CLAIMED,
    ST_RELEASING,
    ST_WAIT_RELEASE_ACK
  } claim_state_t;

  localparam int NDIR = 4;
  localparam int PORT_W = 3;
  localparam logic [PORT_W-1:0] PORT_LOCAL = 3'd4;
endpackage

// File: rtl/tile_prio_pick.sv
module tile_prio_pick #(
  parameter int N = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tile_claim_ctrl.sv
module tile_claim_ctrl
  import tile_claim_pkg::*;
#(
  parameter int CW = 4,
  parameter bit SEED_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NDIR-1:0]          busy_in,
  input  logic [NDIR-1:0]          inv_in,
  input  logic [NDIR-1:0][CW-1:0]  inv_cnt_in,
  input  logic [NDIR-1:0]          cfm_in,
  input  logic [NDIR-1:0][CW-1:0]  cfm_cnt_in,
  input  logic [NDIR-1:0]          rej_in,
  input  logic [NDIR-1:0]          rel_in,
  input  logic [NDIR-1:0]          rak_in,
  input  logic                     seed_inv,
  input  logic [CW-1:0]            seed_cnt,
  input  logic                     seed_rel,
  output logic                     busy_out,
  output logic [NDIR-1:0]          inv_out,
  output logic [CW-1:0]            inv_cnt_out,
  output logic [NDIR-1:0]          cfm_out,
  output logic [CW-1:0]            cfm_cnt_out,
  output logic [NDIR-1:0]          rej_out,
  output logic [NDIR-1:0]          rel_out,
  output logic [NDIR-1:0]          rak_out,
  output logic                     seed_cfm,
  output logic                     seed_rej,
  output logic                     seed_rak
);
  localparam int DW = $clog2(NDIR);
  localparam logic [CW-1:0] ONE = CW'(1);

  claim_state_t       state_q, state_d;
  logic [PORT_W-1:0]  parent_q, parent_d;
  logic [DW-1:0]      child_q, child_d;
  logic               has_child_q, has_child_d;
  logic [CW-1:0]      need_q, need_d;
  logic [NDIR-1:0]    tried_q, tried_d;

  logic [NDIR-1:0] inv_d, cfm_d, rej_d, rel_d, rak_d;
  logic [CW-1:0]   inv_cnt_d, cfm_cnt_d;
  logic            seed_cfm_d, seed_rej_d, seed_rak_d;

  // arrival arbitration: neighbour ports first, local seed last
  logic              seed_ok;
  logic              arr_hit;
  logic [PORT_W-1:0] arr_idx;
  logic [NDIR-1:0]   arr_mask, par_mask, excl, cand;
  logic [CW-1:0]     arr_cnt;
  logic              cand_hit;
  logic [DW-1:0]     cand_idx;

  generate
    if (SEED_EN) begin : g_seed
      assign seed_ok = seed_inv;
    end else begin : g_noseed
      assign seed_ok = 1'b0;
    end
  endgenerate

  tile_prio_pick #(.N(NDIR + 1), .IW(PORT_W)) u_arr_pick (
    .req ({seed_ok, inv_in}),
    .hit (arr_hit),
    .idx (arr_idx)
  );

  assign arr_mask = (arr_idx == PORT_LOCAL) ? '0 : (NDIR'(1) << arr_idx[DW-1:0]);
  assign par_mask = (parent_q == PORT_LOCAL) ? '0 : (NDIR'(1) << parent_q[DW-1:0]);
  assign arr_cnt  = (arr_idx == PORT_LOCAL) ? seed_cnt : inv_cnt_in[arr_idx[DW-1:0]];
  assign excl     = (state_q == ST_FREE) ? arr_mask : (par_mask | tried_q);
  assign cand     = ~busy_in & ~excl;

  tile_prio_pick #(.N(NDIR), .IW(DW)) u_fwd_pick (
    .req (cand),
    .hit (cand_hit),
    .idx (cand_idx)
  );

  logic rel_from_parent;
  logic give_cfm, give_ack;
  assign rel_from_parent = (parent_q == PORT_LOCAL) ? (SEED_EN & seed_rel)
                                                    : rel_in[parent_q[DW-1:0]];

  always_comb begin
    state_d     = state_q;
    parent_d    = parent_q;
    child_d     = child_q;
    has_child_d = has_child_q;
    need_d      = need_q;
    tried_d     = tried_q;
    inv_d       = '0;
    inv_cnt_d   = '0;
    cfm_cnt_d   = '0;
    rel_d       = '0;
    give_cfm    = 1'b0;
    give_ack    = 1'b0;
    // any arrival that is not accepted is rejected
    rej_d       = inv_in;
    seed_rej_d  = seed_ok;

    case (state_q)
      ST_FREE: begin
        if (arr_hit) begin
          rej_d      = inv_in & ~arr_mask;
          seed_rej_d = seed_ok & (arr_idx != PORT_LOCAL);
          parent_d   = arr_idx;
          tried_d    = '0;
          if (arr_cnt > ONE && cand_hit) begin
            inv_d[cand_idx] = 1'b1;
            inv_cnt_d       = arr_cnt - ONE;
            need_d          = arr_cnt - ONE;
            child_d         = cand_idx;
            tried_d         = NDIR'(1) << cand_idx;
            state_d         = ST_WAIT_CONFIRM;
          end else begin
            give_cfm    = 1'b1;
            cfm_cnt_d   = ONE;
            has_child_d = 1'b0;
            state_d     = ST_CLAIMED;
          end
        end
      end
      ST_FORWARDING: begin
        if (cand_hit) begin
          inv_d[cand_idx]   = 1'b1;
          inv_cnt_d         = need_q;
          child_d           = cand_idx;
          tried_d[cand_idx] = 1'b1;
          state_d           = ST_WAIT_CONFIRM;
        end else begin
          give_cfm    = 1'b1;
          cfm_cnt_d   = ONE;
          has_child_d = 1'b0;
          state_d     = ST_CLAIMED;
        end
      end
      ST_WAIT_CONFIRM: begin
        if (cfm_in[child_q]) begin
          give_cfm    = 1'b1;
          cfm_cnt_d   = cfm_cnt_in[child_q] + ONE;
          has_child_d = 1'b1;
          state_d     = ST_CLAIMED;
        end else if (rej_in[child_q]) begin
          state_d = ST_FORWARDING;
        end
      end
      ST_CLAIMED: begin
        if (rel_from_parent) begin
          if (has_child_q) begin
            rel_d[child_q] = 1'b1;
            state_d        = ST_RELEASING;
          end else begin
            give_ack = 1'b1;
            state_d  = ST_FREE;
          end
        end
      end
      ST_RELEASING: state_d = ST_WAIT_RELEASE_ACK;
      ST_WAIT_RELEASE_ACK: begin
        if (rak_in[child_q]) begin
          give_ack = 1'b1;
          state_d  = ST_FREE;
        end
      end
      default: state_d = ST_FREE;
    endcase

    cfm_d      = '0;
    seed_cfm_d = 1'b0;
    rak_d      = '0;
    seed_rak_d = 1'b0;
    if (give_cfm) begin
      if (parent_d == PORT_LOCAL) seed_cfm_d = 1'b1;
      else cfm_d[parent_d[DW-1:0]] = 1'b1;
    end
    if (give_ack) begin
      if (parent_q == PORT_LOCAL) seed_rak_d = 1'b1;
      else rak_d[parent_q[DW-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_FREE;
      parent_q    <= '0;
      child_q     <= '0;
      has_child_q <= 1'b0;
      need_q      <= '0;
      tried_q     <= '0;
      busy_out    <= 1'b0;
      inv_out     <= '0;
      inv_cnt_out <= '0;
      cfm_out     <= '0;
      cfm_cnt_out <= '0;
      rej_out     <= '0;
      rel_out     <= '0;
      rak_out     <= '0;
      seed_cfm    <= 1'b0;
      seed_rej    <= 1'b0;
      seed_rak    <= 1'b0;
    end else begin
      state_q     <= state_d;
      parent_q    <= parent_d;
      child_q     <= child_d;
      has_child_q <= has_child_d;
      need_q      <= need_d;
      tried_q     <= tried_d;
      busy_out    <= (state_d != ST_FREE);
      inv_out     <= inv_d;
      inv_cnt_out <= inv_cnt_d;
      cfm_out     <= cfm_d;
      cfm_cnt_out <= cfm_cnt_d;
      rej_out     <= rej_d;
      rel_out     <= rel_d;
      rak_out     <= rak_d;
      seed_cfm    <= seed_cfm_d;
      seed_rej    <= seed_rej_d;
      seed_rak    <= seed_rak_d;
    end
  end
endmodule

// File: rtl/tile_claim_chk.sv
module tile_claim_chk #(
  parameter int NDIR = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NDIR-1:0] busy_in,
  input logic [NDIR-1:0] inv_in,
  input logic [NDIR-1:0] rel_in,
  input logic [NDIR-1:0] rak_in,
  input logic            seed_rel,
  input logic            busy_out,
  input logic [NDIR-1:0] inv_out,
  input logic [NDIR-1:0] cfm_out,
  input logic [NDIR-1:0] rej_out,
  input logic [NDIR-1:0] rak_out,
  input logic            seed_rak
);
  // forward goes out on at most one port
  assert_single_forward_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inv_out));

  // never forward towards a neighbour that was busy when the decision was taken
  assert_no_busy_target_R3: assert property (@(posedge clk) disable iff (rst)
    (|inv_out) |-> ((inv_out & $past(busy_in)) == '0));

  // a confirm is a single-cycle pulse
  assert_confirm_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (|cfm_out) |=> (cfm_out == '0));

  // a reject only answers a request seen on the same port
  assert_reject_answers_R7: assert property (@(posedge clk) disable iff (rst)
    (|rej_out) |-> ((rej_out & ~$past(inv_in)) == '0));

  // a busy tile with no release traffic stays busy when a request hits it
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_out && (|inv_in) && !(|rel_in) && !seed_rel && !(|rak_in)) |=> busy_out);

  // own release acknowledge coincides with going free
  assert_ack_frees_R11: assert property (@(posedge clk) disable iff (rst)
    ((|rak_out) || seed_rak) |-> !busy_out);
endmodule

bind tile_claim_ctrl tile_claim_chk #(.NDIR(4)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy_in  (busy_in),
  .inv_in   (inv_in),
  .rel_in   (rel_in),
  .rak_in   (rak_in),
  .seed_rel (seed_rel),
  .busy_out (busy_out),
  .inv_out  (inv_out),
  .cfm_out  (cfm_out),
  .rej_out  (rej_out),
  .rak_out  (rak_out),
  .seed_rak (seed_rak)
);

// File: tb/sim_tile_claim_ctrl.sv
`timescale 1ns/1ps
module sim_tile_claim_ctrl;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0]         busy_in = '0, inv_in = '0, cfm_in = '0, rej_in = '0, rel_in = '0, rak_in = '0;
  logic [3:0][CW-1:0] inv_cnt_in = '0, cfm_cnt_in = '0;
  logic               seed_inv = 1'b0, seed_rel = 1'b0;
  logic [CW-1:0]      seed_cnt = '0;

  logic          busy_out, seed_cfm, seed_rej, seed_rak;
  logic [3:0]    inv_out, cfm_out, rej_out, rel_out, rak_out;
  logic [CW-1:0] inv_cnt_out, cfm_cnt_out;

  logic          b1_busy, b1_scfm, b1_srej, b1_srak;
  logic [3:0]    b1_inv, b1_cfm, b1_rej, b1_rel, b1_rak;
  logic [CW-1:0] b1_icnt, b1_ccnt;

  tile_claim_ctrl #(.CW(CW), .SEED_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .busy_in(busy_in), .inv_in(inv_in), .inv_cnt_in(inv_cnt_in),
    .cfm_in(cfm_in), .cfm_cnt_in(cfm_cnt_in), .rej_in(rej_in), .rel_in(rel_in),
    .rak_in(rak_in), .seed_inv(seed_inv), .seed_cnt(seed_cnt), .seed_rel(seed_rel),
    .busy_out(busy_out), .inv_out(inv_out), .inv_cnt_out(inv_cnt_out), .cfm_out(cfm_out),
    .cfm_cnt_out(cfm_cnt_out), .rej_out(rej_out), .rel_out(rel_out), .rak_out(rak_out),
    .seed_cfm(seed_cfm), .seed_rej(seed_rej), .seed_rak(seed_rak));

  tile_claim_ctrl #(.CW(CW), .SEED_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .busy_in(busy_in), .inv_in(inv_in), .inv_cnt_in(inv_cnt_in),
    .cfm_in(cfm_in), .cfm_cnt_in(cfm_cnt_in), .rej_in(rej_in), .rel_in(rel_in),
    .rak_in(rak_in), .seed_inv(seed_inv), .seed_cnt(seed_cnt), .seed_rel(seed_rel),
    .busy_out(b1_busy), .inv_out(b1_inv), .inv_cnt_out(b1_icnt), .cfm_out(b1_cfm),
    .cfm_cnt_out(b1_ccnt), .rej_out(b1_rej), .rel_out(b1_rel), .rak_out(b1_rak),
    .seed_cfm(b1_scfm), .seed_rej(b1_srej), .seed_rak(b1_srak));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one edge; inputs applied before are sampled there, then cleared
  task automatic step();
    @(posedge clk);
    #1;
    inv_in = '0; cfm_in = '0; rej_in = '0; rel_in = '0; rak_in = '0;
    seed_inv = 1'b0; seed_rel = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    busy_in = '0;
    step(); step();
    rst = 1'b0;
  endtask

  function automatic int first_free(input int p, input logic [3:0] m, input logic [3:0] tried);
    for (int i = 0; i < 4; i++)
      if (i != p && !m[i] && !tried[i]) return i;
    return -1;
  endfunction

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 busy", busy_out, 0);
    chk("R1 pulses", int'({inv_out, cfm_out, rej_out, rel_out, rak_out}), 0);
    chk("R1 seed pulses", int'({seed_cfm, seed_rej, seed_rak}), 0);

    // R10 seed on border tile, count 1; u1 has the seed port off
    seed_inv = 1'b1; seed_cnt = 4'd1; step();
    chk("R10 seed confirm", seed_cfm, 1);
    chk("R10 seed count", cfm_cnt_out, 1);
    chk("R10 disabled seed no reply", int'({b1_scfm, b1_srej}), 0);
    chk("R10 disabled seed stays free", b1_busy, 0);
    seed_rel = 1'b1; step();
    chk("R10 seed release ack", seed_rak, 1);
    chk("R11 free after seed ack", busy_out, 0);

    // seed count 2: forward east, child confirms 1 -> seed confirm 2
    seed_inv = 1'b1; seed_cnt = 4'd2; step();
    chk("R2 seed forward east", inv_out, 1);
    chk("R2 seed forward count", inv_cnt_out, 1);
    cfm_in[0] = 1'b1; cfm_cnt_in[0] = 4'd1; step();
    chk("R5 seed confirm", seed_cfm, 1);
    chk("R5 seed confirm count", cfm_cnt_out, 2);
    chk("R10 disabled seed still free", b1_busy, 0);
    do_reset();

    // sweep: entry port x busy pattern x count
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 16; m++) begin
        for (int ci = 0; ci < 2; ci++) begin
          automatic int cnt = (ci == 0) ? 1 : 3;
          automatic int c = first_free(p, 4'(m), 4'b0);
          automatic bit fwd = (cnt > 1) && (c >= 0);
          busy_in = 4'(m);
          inv_in[p] = 1'b1; inv_cnt_in[p] = 4'(cnt); step();
          chk("R11 busy after accept", busy_out, 1);
          if (fwd) begin
            chk("R2 forward port", inv_out, 1 << c);
            chk("R2 forward count", inv_cnt_out, cnt - 1);
            chk("R3 no confirm yet", cfm_out, 0);
            cfm_in[c] = 1'b1; cfm_cnt_in[c] = 4'd2; step();
            chk("R5 confirm port", cfm_out, 1 << p);
            chk("R5 confirm count", cfm_cnt_out, 3);
            rel_in[p] = 1'b1; step();
            chk("R8 release forwarded", rel_out, 1 << c);
            chk("R11 busy while releasing", busy_out, 1);
            step();
            rak_in[c] = 1'b1; step();
            chk("R9 ack to source", rak_out, 1 << p);
            chk("R9 free after ack", busy_out, 0);
          end else begin
            chk("R3 R4 no forward", inv_out, 0);
            chk("R3 R4 confirm port", cfm_out, 1 << p);
            chk("R3 R4 confirm count", cfm_cnt_out, 1);
            rel_in[p] = 1'b1; step();
            chk("R8 leaf ack", rak_out, 1 << p);
            chk("R8 leaf free", busy_out, 0);
          end
          step();
          chk("R11 idle after chain", int'({busy_out, inv_out, cfm_out, rak_out}), 0);
        end
      end
    end
    busy_in = '0;

    // R6 reject retry: entry west, count 3
    inv_in[2] = 1'b1; inv_cnt_in[2] = 4'd3; step();
    chk("R2 first try east", inv_out, 1);
    rej_in[0] = 1'b1; step();
    chk("R6 no output in retry cycle", inv_out, 0);
    step();
    chk("R6 retry south", inv_out, 2);
    chk("R6 retry count", inv_cnt_out, 2);
    rej_in[1] = 1'b1; step(); step();
    chk("R6 retry north skips entry", inv_out, 8);
    rej_in[3] = 1'b1; step(); step();
    chk("R6 R4 partial confirm port", cfm_out, 4);
    chk("R6 R4 partial confirm count", cfm_cnt_out, 1);
    rel_in[2] = 1'b1; step();
    chk("R8 leaf ack after retry", rak_out, 4);

    // R7 busy tile rejects, state kept; R8 release on wrong port ignored
    inv_in[3] = 1'b1; inv_cnt_in[3] = 4'd1; step();
    chk("R3 north leaf confirm", cfm_out, 8);
    inv_in[0] = 1'b1; inv_cnt_in[0] = 4'd2; step();
    chk("R7 reject east", rej_out, 1);
    chk("R7 still busy", busy_out, 1);
    chk("R7 no forward", inv_out, 0);
    step();
    chk("R7 reject is one cycle", rej_out, 0);
    rel_in[0] = 1'b1; step();
    chk("R8 wrong-port release ignored", rak_out, 0);
    chk("R8 wrong-port release keeps busy", busy_out, 1);
    rel_in[3] = 1'b1; step();
    chk("R8 ack on original path", rak_out, 8);
    chk("R11 free", busy_out, 0);

    // R7 simultaneous arrivals: east wins, west rejected
    inv_in = 4'b0101; inv_cnt_in[0] = 4'd1; inv_cnt_in[2] = 4'd1; step();
    chk("R2 east wins", cfm_out, 1);
    chk("R7 west loses", rej_out, 4);
    rel_in[0] = 1'b1; step();
    chk("R8 ack winner", rak_out, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule